// File: doc/BRIEF.md
# Serial DAC Command Frame Transmitter

This block sits on the host side of a three-wire link to a quad voltage-output DAC. A client hands it a channel address, a two-bit operation code and a twelve-bit sample in one valid/ready transfer. The block packs these into a sixteen-bit command word. It then drives the frame line (active-low select), the serial clock and the serial data line from the system clock.

The slave latches data on falling serial-clock edges and acts on a word once it has seen sixteen of them. Because of this, the transmitter enforces the slave's framing rules itself. The clock is parked low. Data moves only while the clock rises. The select line never drops on a clock fall. A programmable high pulse on the select line closes every frame. Select and data both rest low between frames to save receiver current.

The serial clock half-period, the closing select-high pulse and an optional mid-frame pause are runtime counts in system clocks. All three are captured when a transfer is accepted. In split mode the word leaves as two eight-bit bursts, and the select line stays low through the pause between them.

Top module: `dac_frame_tx`

## Requirements
- R1: The word is sent most significant bit first as {inAddr[1:0], inOp[1:0], inData[11:0]}. Bit 15 is on dinOut from the first cycle after acceptance. Each later bit appears together with a rising sclkOut.
- R2: sclkOut is low whenever no frame is active. Each high phase and each low phase lasts max(divCount,1) system clocks. dinOut never changes in a cycle where sclkOut falls.
- R3: After acceptance, sclkOut stays low for max(divCount,1) cycles before its first rise. syncOut never falls in a cycle where sclkOut falls.
- R4: Exactly 16 sclkOut falling edges occur while syncOut is low in each frame.
- R5: The low phase after the sixteenth fall lasts max(divCount,1) cycles. One further hold cycle follows with sclkOut and dinOut low. syncOut is then high for max(syncHiCount,1) cycles and then returns low.
- R6: With splitMode set at acceptance, after the eighth fall sclkOut stays low for an extra max(gapCount,1) cycles. During this pause syncOut stays low and dinOut keeps the eighth bit. The ninth bit follows with the next rise.
- R7: inReady is high only while idle. busy is high from the cycle after acceptance until syncOut returns low. inValid and the field inputs have no effect while busy.
- R8: During and after reset, syncOut, sclkOut and dinOut are low, busy is low and inReady is high.
- R9: While idle, syncOut, sclkOut and dinOut are all held low.
- R10: divCount, gapCount, syncHiCount and splitMode are captured at acceptance. Changing them during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Command offered |
| inReady | output | 1 | Block idle and able to accept |
| inAddr | input | 2 | Channel address field |
| inOp | input | 2 | Operation field |
| inData | input | 12 | Sample field |
| splitMode | input | 1 | Send as two eight-bit bursts |
| divCount | input | 8 | Serial clock half-period in system clocks (0 treated as 1) |
| gapCount | input | 8 | Mid-frame pause length in split mode (0 treated as 1) |
| syncHiCount | input | 8 | Closing select-high length (0 treated as 1) |
| busy | output | 1 | Frame or closing pulse in progress |
| syncOut | output | 1 | Frame select to the slave, active low |
| sclkOut | output | 1 | Serial clock to the slave |
| dinOut | output | 1 | Serial data to the slave |

## Verification
The bench goes after zero-valued counts. A design that failed to clamp them would skip the setup phase or the closing pulse, or would wrap a counter and stall. It also holds inValid high across a whole frame with fields changing mid-frame. A design that re-latched would corrupt the running word or start a second frame too early. Split frames are compared bit by bit through the pause, which catches a ninth bit sent one burst early or a select that rises in the gap. Timing inputs are rewritten while a frame runs to expose any design that reads them live instead of from the captured copy.

// File: rtl/dac_tx_pkg.sv
package dac_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SHIFT_HI,
    ST_SHIFT_LO,
    ST_GAP,
    ST_HOLD,
    ST_SYNC_HI
  } txState_e;

  // one-cycle commands from control to datapath
  typedef struct packed {
    logic load;
    logic sclkRise;
    logic sclkFall;
    logic shift;
    logic park;
    logic syncSet;
    logic syncClr;
  } txStrobe_t;

endpackage

// File: rtl/dac_tx_ctrl.sv
module dac_tx_ctrl
  import dac_tx_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int GAP_W   = 8,
  parameter int HI_W    = 8,
  parameter int FRAME_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             splitMode,
  input  logic [DIV_W-1:0] divCount,
  input  logic [GAP_W-1:0] gapCount,
  input  logic [HI_W-1:0]  syncHiCount,
  output logic             inReady,
  output logic             busy,
  output txStrobe_t        strobe
);

  localparam int TMR_A   = (DIV_W > GAP_W) ? DIV_W : GAP_W;
  localparam int TMR_W   = (TMR_A > HI_W) ? TMR_A : HI_W;
  localparam int BIT_W   = $clog2(FRAME_W);
  localparam int BURST_W = FRAME_W / 2;

  txState_e           state, stateN;
  logic [TMR_W-1:0]   tmr, tmrN;
  logic [BIT_W-1:0]   bitCnt, bitCntN;
  logic [DIV_W-1:0]   divL;
  logic [GAP_W-1:0]   gapL;
  logic [HI_W-1:0]    hiL;
  logic               splitL;
  logic               lastTick;

  function automatic logic [TMR_W-1:0] atLeastOne(input logic [TMR_W-1:0] v);
    return (v == '0) ? TMR_W'(1) : v;
  endfunction

  assign lastTick = (tmr == TMR_W'(1));
  assign inReady  = (state == ST_IDLE);
  assign busy     = (state != ST_IDLE);

  always_comb begin
    stateN  = state;
    tmrN    = lastTick ? tmr : tmr - TMR_W'(1);
    bitCntN = bitCnt;
    strobe  = '0;
    case (state)
      ST_IDLE: begin
        tmrN = tmr;
        if (inValid) begin
          stateN      = ST_SETUP;
          tmrN        = atLeastOne(TMR_W'(divCount));
          bitCntN     = BIT_W'(FRAME_W - 1);
          strobe.load = 1'b1;
        end
      end
      ST_SETUP: if (lastTick) begin
        stateN          = ST_SHIFT_HI;
        tmrN            = atLeastOne(TMR_W'(divL));
        strobe.sclkRise = 1'b1;
      end
      ST_SHIFT_HI: if (lastTick) begin
        stateN          = ST_SHIFT_LO;
        tmrN            = atLeastOne(TMR_W'(divL));
        strobe.sclkFall = 1'b1;
      end
      ST_SHIFT_LO: if (lastTick) begin
        if (bitCnt == '0) begin
          stateN      = ST_HOLD;
          tmrN        = TMR_W'(1);
          strobe.park = 1'b1;
        end else if (splitL && bitCnt == BIT_W'(BURST_W)) begin
          stateN = ST_GAP;
          tmrN   = atLeastOne(TMR_W'(gapL));
        end else begin
          stateN          = ST_SHIFT_HI;
          tmrN            = atLeastOne(TMR_W'(divL));
          bitCntN         = bitCnt - BIT_W'(1);
          strobe.sclkRise = 1'b1;
          strobe.shift    = 1'b1;
        end
      end
      ST_GAP: if (lastTick) begin
        stateN          = ST_SHIFT_HI;
        tmrN            = atLeastOne(TMR_W'(divL));
        bitCntN         = bitCnt - BIT_W'(1);
        strobe.sclkRise = 1'b1;
        strobe.shift    = 1'b1;
      end
      ST_HOLD: begin
        stateN         = ST_SYNC_HI;
        tmrN           = atLeastOne(TMR_W'(hiL));
        strobe.syncSet = 1'b1;
      end
      ST_SYNC_HI: if (lastTick) begin
        stateN         = ST_IDLE;
        strobe.syncClr = 1'b1;
      end
      default: stateN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      tmr    <= TMR_W'(1);
      bitCnt <= '0;
      divL   <= '0;
      gapL   <= '0;
      hiL    <= '0;
      splitL <= 1'b0;
    end else begin
      state  <= stateN;
      tmr    <= tmrN;
      bitCnt <= bitCntN;
      if (strobe.load) begin
        divL   <= divCount;
        gapL   <= gapCount;
        hiL    <= syncHiCount;
        splitL <= splitMode;
      end
    end
  end

  // R7
  accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inReady && inValid) |=> (busy && !inReady));

endmodule

// File: rtl/dac_tx_dpath.sv
module dac_tx_dpath
  import dac_tx_pkg::*;
#(
  parameter int ADDR_W  = 2,
  parameter int OP_W    = 2,
  parameter int DATA_W  = 12,
  parameter int FRAME_W = ADDR_W + OP_W + DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strobe,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [OP_W-1:0]   inOp,
  input  logic [DATA_W-1:0] inData,
  output logic              syncOut,
  output logic              sclkOut,
  output logic              dinOut
);

  logic [FRAME_W-1:0] shReg;
  logic [FRAME_W-1:0] frameWord;

  assign frameWord = {inAddr, inOp, inData};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg   <= '0;
      syncOut <= 1'b0;
      sclkOut <= 1'b0;
      dinOut  <= 1'b0;
    end else begin
      if (strobe.load) begin
        shReg  <= frameWord << 1;
        dinOut <= frameWord[FRAME_W-1];
      end
      if (strobe.shift) begin
        shReg  <= shReg << 1;
        dinOut <= shReg[FRAME_W-1];
      end
      if (strobe.sclkRise) sclkOut <= 1'b1;
      if (strobe.sclkFall) sclkOut <= 1'b0;
      if (strobe.park) begin
        sclkOut <= 1'b0;
        dinOut  <= 1'b0;
      end
      if (strobe.syncSet) syncOut <= 1'b1;
      if (strobe.syncClr) syncOut <= 1'b0;
    end
  end

  // R2
  din_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclkOut) |-> $stable(dinOut));

  // R3
  sync_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(syncOut) |-> (!sclkOut && $past(!sclkOut)));

endmodule

// File: rtl/dac_frame_tx.sv
module dac_frame_tx #(
  parameter int ADDR_W = 2,
  parameter int OP_W   = 2,
  parameter int DATA_W = 12,
  parameter int DIV_W  = 8,
  parameter int GAP_W  = 8,
  parameter int HI_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [OP_W-1:0]   inOp,
  input  logic [DATA_W-1:0] inData,
  input  logic              splitMode,
  input  logic [DIV_W-1:0]  divCount,
  input  logic [GAP_W-1:0]  gapCount,
  input  logic [HI_W-1:0]   syncHiCount,
  output logic              busy,
  output logic              syncOut,
  output logic              sclkOut,
  output logic              dinOut
);

  localparam int FRAME_W = ADDR_W + OP_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  dac_tx_pkg::txStrobe_t strobe;

  dac_tx_ctrl #(
    .DIV_W(DIV_W), .GAP_W(GAP_W), .HI_W(HI_W), .FRAME_W(FRAME_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .splitMode(splitMode),
    .divCount(divCount), .gapCount(gapCount), .syncHiCount(syncHiCount),
    .inReady(inReady), .busy(busy), .strobe(strobe)
  );

  dac_tx_dpath #(
    .ADDR_W(ADDR_W), .OP_W(OP_W), .DATA_W(DATA_W), .FRAME_W(FRAME_W)
  ) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .inAddr(inAddr), .inOp(inOp), .inData(inData),
    .syncOut(syncOut), .sclkOut(sclkOut), .dinOut(dinOut)
  );

  // checker state: falling edges seen since select last went low
  logic             sclkPrev;
  logic [CNT_W-1:0] fallCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev <= 1'b0;
      fallCnt  <= '0;
    end else begin
      sclkPrev <= sclkOut;
      if (syncOut) fallCnt <= '0;
      else if (sclkPrev && !sclkOut) fallCnt <= fallCnt + CNT_W'(1);
    end
  end

  // R4
  fall_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(syncOut) |-> (fallCnt == CNT_W'(FRAME_W)));

  // R5
  close_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(syncOut) |-> (!sclkOut && !dinOut && $past(!sclkOut) && $past(!sclkOut, 2)));

  // R9
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> (!syncOut && !sclkOut && !dinOut && !busy));

endmodule

// File: tb/sim_dac_frame_tx.sv
module sim_dac_frame_tx;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [1:0]  inAddr = '0;
  logic [1:0]  inOp = '0;
  logic [11:0] inData = '0;
  logic        splitMode = 1'b0;
  logic [7:0]  divCount = '0;
  logic [7:0]  gapCount = '0;
  logic [7:0]  syncHiCount = '0;
  logic        inReady, busy, syncOut, sclkOut, dinOut;

  dac_frame_tx u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inAddr(inAddr), .inOp(inOp), .inData(inData), .splitMode(splitMode),
    .divCount(divCount), .gapCount(gapCount), .syncHiCount(syncHiCount),
    .busy(busy), .syncOut(syncOut), .sclkOut(sclkOut), .dinOut(dinOut)
  );

  int checks = 0;
  int failures = 0;
  string tag = "R8 reset";
  bit done = 0;
  logic [4:0] expQ[$];   // {sync, sclk, din, busy, ready}
  bit modelReady = 1;
  int falls = 0;
  logic prevSclk = 1'b0;
  logic prevSync = 1'b0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s [%s] act=%0h exp=%0h at %0t", req, tag, act, exp, $time);
    end
  endtask

  task automatic pushN(int n, logic [4:0] v);
    for (int i = 0; i < n; i++) expQ.push_back(v);
  endtask

  // reference: the expected output of every cycle of one frame
  task automatic pushFrame(logic [15:0] w, bit sp, int dv, int gp, int hi);
    int d = (dv == 0) ? 1 : dv;
    int g = (gp == 0) ? 1 : gp;
    int h = (hi == 0) ? 1 : hi;
    pushN(d, {1'b0, 1'b0, w[15], 1'b1, 1'b0});
    for (int k = 15; k >= 0; k--) begin
      pushN(d, {1'b0, 1'b1, w[k], 1'b1, 1'b0});
      pushN(d, {1'b0, 1'b0, w[k], 1'b1, 1'b0});
      if (sp && k == 8) pushN(g, {1'b0, 1'b0, w[8], 1'b1, 1'b0});
    end
    pushN(1, 5'b00010);
    pushN(h, 5'b10010);
  endtask

  always @(posedge clk) begin
    if (rstN && inValid && modelReady)
      pushFrame({inAddr, inOp, inData}, splitMode, divCount, gapCount, syncHiCount);
  end

  always @(negedge clk) begin
    logic [4:0] e;
    if (rstN) begin
      if (expQ.size() > 0) begin
        e = expQ.pop_front();
        modelReady = 0;
      end else begin
        e = 5'b00001;
        modelReady = 1;
      end
      chk("R5 sync", syncOut, e[4]);
      chk("R2 sclk", sclkOut, e[3]);
      chk("R1 din", dinOut, e[2]);
      chk("R7 busy", busy, e[1]);
      chk("R7 ready", inReady, e[0]);
      if (prevSync && !syncOut) chk("R3 sync fall with sclk fall", prevSclk && !sclkOut, 0);
      if (!syncOut && prevSclk && !sclkOut) falls++;
      if (!prevSync && syncOut) chk("R4 falls per frame", falls, 16);
      if (syncOut) falls = 0;
      prevSclk = sclkOut;
      prevSync = syncOut;
    end
  end

  task automatic waitIdle();
    do @(negedge clk); while (busy === 1'b1);
    repeat (2) @(negedge clk);
  endtask

  task automatic send(logic [1:0] a, logic [1:0] o, logic [11:0] d,
                      bit sp, int dv, int gp, int hi);
    @(negedge clk);
    #1;
    inAddr = a; inOp = o; inData = d; splitMode = sp;
    divCount = 8'(dv); gapCount = 8'(gp); syncHiCount = 8'(hi);
    inValid = 1'b1;
    @(negedge clk);
    #1 inValid = 1'b0;
    waitIdle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8 outputs held in reset
    chk("R8 reset sync", syncOut, 0);
    chk("R8 reset sclk", sclkOut, 0);
    chk("R8 reset din", dinOut, 0);
    chk("R8 reset busy", busy, 0);
    chk("R8 reset ready", inReady, 1);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk("R8 after reset ready", inReady, 1);

    tag = "R1 basic div1";
    send(2'b10, 2'b01, 12'hA5C, 0, 1, 0, 1);
    tag = "R2 div3 all ones";
    send(2'b11, 2'b11, 12'hFFF, 0, 3, 0, 4);
    tag = "R3 alternating div2";
    send(2'b01, 2'b10, 12'h555, 0, 2, 0, 2);
    tag = "R6 split gap5";
    send(2'b11, 2'b00, 12'h0F0, 1, 2, 5, 2);
    tag = "R6 split zero counts";
    send(2'b00, 2'b11, 12'hFFF, 1, 0, 0, 0);
    tag = "R5 long sync high";
    send(2'b10, 2'b10, 12'h001, 0, 1, 0, 9);

    // R10: timing inputs rewritten mid-frame
    tag = "R10 config captured";
    @(negedge clk);
    #1;
    inAddr = 2'b01; inOp = 2'b00; inData = 12'h3C3; splitMode = 0;
    divCount = 8'd2; gapCount = 8'd1; syncHiCount = 8'd3; inValid = 1'b1;
    @(negedge clk);
    #1;
    inValid = 1'b0; divCount = 8'd7; syncHiCount = 8'd9; splitMode = 1; gapCount = 8'd6;
    waitIdle();

    // R7: valid held while busy, fields changed mid-frame
    tag = "R7 valid held";
    @(negedge clk);
    #1;
    inAddr = 2'b10; inOp = 2'b01; inData = 12'h812; splitMode = 0;
    divCount = 8'd1; gapCount = 8'd0; syncHiCount = 8'd2; inValid = 1'b1;
    repeat (10) @(negedge clk);
    #1;
    inAddr = 2'b01; inOp = 2'b11; inData = 12'h7E1;
    do @(negedge clk); while (busy === 1'b1);
    @(negedge clk);
    #1 inValid = 1'b0;
    waitIdle();

    tag = "R9 idle lines";
    repeat (20) @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule